// File: doc/BRIEF.md
# Skip-Aware Fetch Sequencer

This block sits between a synchronous program memory and the execute stage of a single-issue controller whose instructions are 16 bits wide. Every cycle it presents the newly fetched word to execute and says whether that slot is a real instruction, the operand half of a two-word move, or a bubble that must not write any register or flag. Execute answers in the same cycle with a skip-taken flag, a program-counter-write flag and a jump target. The sequencer turns these answers into bubbles and a new fetch address.

Two-word moves are recognised by the top four bits of their words. A head word (1100) is always followed by its operand word (1111), which the move consumes. An operand word reached on its own is a harmless one-cycle no-operation. When a skip lands on a head word, both halves are flushed, so the skip costs three cycles instead of two. Each finished instruction is reported once, one cycle after its last slot, with its start address and the number of cycles it used.

Top module: `fetch_skip_seq`

## Requirements
- R1: A synchronous, active-high reset sets fetch_addr to 0 and drops issue_valid, issue_operand and retire_valid. The first slot after release is an idle boot cycle. The word at address 0 is issued, with issue_pc 0, in the next cycle.
- R2: In normal flow a word whose top nibble is neither 1100 nor 1111 is issued with issue_valid high. issue_word and issue_pc show the word and its address, addresses go up by one per slot, and the instruction retires using 1 cycle.
- R3: When skip_taken is high in a slot with issue_valid high holding a one-word instruction, the next slot is a bubble. A word other than 1100 in that slot is flushed alone, and the skipping instruction retires using 2 cycles.
- R4: If the word flushed by a skip has top nibble 1100, the slot after it is also a bubble, and the skipping instruction retires using 3 cycles.
- R5: pc_write in a slot with issue_valid high holding a one-word instruction makes the next slot a bubble, sets fetch_addr to pc_target in that bubble cycle, and issues the word at pc_target in the cycle after. The instruction retires using 2 cycles.
- R6: When pc_write and skip_taken are high together, the jump wins: exactly one bubble follows, even if the flushed word is a 1100 head.
- R7: A word with top nibble 1100 in normal flow is issued valid, and the next slot carries its operand with issue_operand high and issue_valid low. The move retires using 2 cycles.
- R8: A word with top nibble 1111 reached in normal flow is issued with issue_valid and issue_operand both low, and retires as a 1-cycle no-operation.
- R9: skip_taken and pc_write have no effect in boot, bubble, operand or lone-1111 slots, nor in the slot of a 1100 head.
- R10: retire_valid pulses for one cycle, one cycle after an instruction's last slot. retire_pc gives the address of its first word, and retire_cycles a nonzero count of the cycles it used.
- R11: A reset in the middle of a skip or jump flush discards the pending flush. The word at address 0 is then issued as a valid instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | output | ADDR_W | Address sent to program memory; its word returns the next cycle |
| fetch_word | input | WORD_W | Registered read data from program memory |
| skip_taken | input | 1 | Execute: the current instruction's condition calls for a skip |
| pc_write | input | 1 | Execute: the current instruction writes the program counter |
| pc_target | input | ADDR_W | New program counter value, used with pc_write |
| issue_word | output | WORD_W | Word in the current slot |
| issue_pc | output | ADDR_W | Address of the word in the current slot |
| issue_valid | output | 1 | Slot is a real instruction that may write state |
| issue_operand | output | 1 | Slot is the operand word of a two-word move |
| retire_valid | output | 1 | An instruction finished in the previous cycle |
| retire_pc | output | ADDR_W | Address of the retired instruction's first word |
| retire_cycles | output | CNT_W | Cycles the retired instruction used |

## Verification
On every cycle the assertions check the local consequences of execute's answers. A skip on a plain slot is followed by a bubble, a skipped head drags a second bubble, and a jump gives exactly one bubble and then lands on the target address. An operand slot only ever follows a head, and every retire report carries a nonzero cycle count. Only the bench's scenarios can show that the whole address stream and the 1/2/3 cycle totals match a program. These include stimulus that must be ignored, the jump-over-skip priority, and a reset that cuts into a flush, all checked against a model of the memory contents.

// File: rtl/fskip_pkg.sv
package fskip_pkg;

  typedef enum logic [2:0] {
    ST_BOOT       = 3'd0,
    ST_RUN        = 3'd1,
    ST_OPER       = 3'd2,
    ST_FLUSH_SKIP = 3'd3,
    ST_FLUSH_JMP  = 3'd4,
    ST_FLUSH_TAIL = 3'd5
  } seq_state_e;

  typedef enum logic [2:0] {
    SLOT_IDLE   = 3'd0,
    SLOT_EXEC   = 3'd1,
    SLOT_OPER   = 3'd2,
    SLOT_BUBBLE = 3'd3,
    SLOT_NOP    = 3'd4
  } slot_kind_e;

  typedef struct packed {
    logic head;
    logic tail;
  } word_class_t;

endpackage

// File: rtl/fskip_word_class.sv
module fskip_word_class
  import fskip_pkg::*;
#(
  parameter int              OPC_W     = 4,
  parameter logic [OPC_W-1:0] HEAD_CODE = 4'b1100,
  parameter logic [OPC_W-1:0] TAIL_CODE = 4'b1111,
  parameter bit              PAIR_EN   = 1'b1
) (
  input  logic [OPC_W-1:0] opc,
  output word_class_t      cls
);

  // Pair decoding can be disabled for cores without two-word moves.
  assign cls.head = PAIR_EN && (opc == HEAD_CODE);
  assign cls.tail = PAIR_EN && (opc == TAIL_CODE);

endmodule

// File: rtl/fskip_fetch_ctrl.sv
module fskip_fetch_ctrl #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] slot_pc
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_addr <= '0;
      slot_pc    <= '0;
    end else begin
      slot_pc    <= fetch_addr;
      fetch_addr <= redirect ? target : fetch_addr + ADDR_ONE;
    end
  end

  // R5
  redirect_land_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && redirect) |=> (fetch_addr == $past(target)));

endmodule

// File: rtl/fskip_slot_fsm.sv
module fskip_slot_fsm
  import fskip_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  word_class_t cls,
  input  logic        skip_taken,
  input  logic        pc_write,
  output slot_kind_e  slot_kind,
  output logic        redirect,
  output logic        slot_start,
  output logic        slot_last
);

  seq_state_e state_q, state_d;
  logic       exec_plain;

  assign exec_plain = (state_q == ST_RUN) && !cls.head && !cls.tail;

  always_comb begin
    state_d    = state_q;
    slot_kind  = SLOT_BUBBLE;
    redirect   = 1'b0;
    slot_start = 1'b0;
    slot_last  = 1'b0;
    unique case (state_q)
      ST_BOOT: begin
        slot_kind = SLOT_IDLE;
        state_d   = ST_RUN;
      end
      ST_RUN: begin
        slot_start = 1'b1;
        if (cls.tail) begin
          slot_kind = SLOT_NOP;
          slot_last = 1'b1;
        end else if (cls.head) begin
          slot_kind = SLOT_EXEC;
          state_d   = ST_OPER;
        end else begin
          slot_kind = SLOT_EXEC;
          if (pc_write) begin
            redirect = 1'b1;
            state_d  = ST_FLUSH_JMP;
          end else if (skip_taken) begin
            state_d = ST_FLUSH_SKIP;
          end else begin
            slot_last = 1'b1;
          end
        end
      end
      ST_OPER: begin
        slot_kind = SLOT_OPER;
        slot_last = 1'b1;
        state_d   = ST_RUN;
      end
      ST_FLUSH_JMP: begin
        slot_last = 1'b1;
        state_d   = ST_RUN;
      end
      ST_FLUSH_SKIP: begin
        if (cls.head) begin
          state_d = ST_FLUSH_TAIL;
        end else begin
          slot_last = 1'b1;
          state_d   = ST_RUN;
        end
      end
      ST_FLUSH_TAIL: begin
        slot_last = 1'b1;
        state_d   = ST_RUN;
      end
      default: begin
        slot_kind = SLOT_IDLE;
        state_d   = ST_BOOT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_BOOT;
    else     state_q <= state_d;
  end

  // R3
  skip_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && exec_plain && skip_taken && !pc_write) |=> (slot_kind == SLOT_BUBBLE));

  // R4
  pair_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && state_q == ST_FLUSH_SKIP && cls.head) |=> (slot_kind == SLOT_BUBBLE));

  // R5
  jump_single_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && exec_plain && pc_write) |=> (slot_kind == SLOT_BUBBLE) ##1
      (slot_kind == SLOT_EXEC || slot_kind == SLOT_NOP));

  // R7
  head_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && state_q == ST_RUN && cls.head) |=> (slot_kind == SLOT_OPER));

  // R7
  operand_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_kind == SLOT_OPER) |-> ($past(slot_kind) == SLOT_EXEC && !$past(slot_last)));

endmodule

// File: rtl/fskip_cycle_meter.sv
module fskip_cycle_meter #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_start,
  input  logic              slot_last,
  input  logic [ADDR_W-1:0] slot_pc,
  output logic              retire_valid,
  output logic [ADDR_W-1:0] retire_pc,
  output logic [CNT_W-1:0]  retire_cycles
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  acc_q, cur;
  logic [ADDR_W-1:0] start_pc_q;

  always_comb begin
    if (slot_start)             cur = CNT_ONE;
    else if (acc_q == CNT_MAX)  cur = CNT_MAX;
    else                        cur = acc_q + CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q         <= '0;
      start_pc_q    <= '0;
      retire_valid  <= 1'b0;
      retire_pc     <= '0;
      retire_cycles <= '0;
    end else begin
      acc_q        <= slot_last ? '0 : cur;
      retire_valid <= slot_last;
      if (slot_start) start_pc_q <= slot_pc;
      if (slot_last) begin
        retire_cycles <= cur;
        retire_pc     <= slot_start ? slot_pc : start_pc_q;
      end
    end
  end

  // R10
  retire_count_chk: assert property (@(posedge clk) disable iff (rst)
    retire_valid |-> (retire_cycles != '0));

endmodule

// File: rtl/fetch_skip_seq.sv
module fetch_skip_seq
  import fskip_pkg::*;
#(
  parameter int               ADDR_W    = 10,
  parameter int               WORD_W    = 16,
  parameter int               OPC_W     = 4,
  parameter int               CNT_W     = 2,
  parameter logic [OPC_W-1:0] HEAD_CODE = 4'b1100,
  parameter logic [OPC_W-1:0] TAIL_CODE = 4'b1111,
  parameter bit               PAIR_EN   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              skip_taken,
  input  logic              pc_write,
  input  logic [ADDR_W-1:0] pc_target,
  output logic [WORD_W-1:0] issue_word,
  output logic [ADDR_W-1:0] issue_pc,
  output logic              issue_valid,
  output logic              issue_operand,
  output logic              retire_valid,
  output logic [ADDR_W-1:0] retire_pc,
  output logic [CNT_W-1:0]  retire_cycles
);

  localparam int OPC_LSB = WORD_W - OPC_W;

  word_class_t       cls;
  slot_kind_e        slot_kind;
  logic              redirect, slot_start, slot_last;
  logic [ADDR_W-1:0] slot_pc;

  fskip_word_class #(
    .OPC_W(OPC_W), .HEAD_CODE(HEAD_CODE), .TAIL_CODE(TAIL_CODE), .PAIR_EN(PAIR_EN)
  ) u_class (
    .opc (fetch_word[WORD_W-1:OPC_LSB]),
    .cls (cls)
  );

  fskip_slot_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .cls        (cls),
    .skip_taken (skip_taken),
    .pc_write   (pc_write),
    .slot_kind  (slot_kind),
    .redirect   (redirect),
    .slot_start (slot_start),
    .slot_last  (slot_last)
  );

  fskip_fetch_ctrl #(.ADDR_W(ADDR_W)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .redirect   (redirect),
    .target     (pc_target),
    .fetch_addr (fetch_addr),
    .slot_pc    (slot_pc)
  );

  fskip_cycle_meter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_meter (
    .clk           (clk),
    .rst           (rst),
    .slot_start    (slot_start),
    .slot_last     (slot_last),
    .slot_pc       (slot_pc),
    .retire_valid  (retire_valid),
    .retire_pc     (retire_pc),
    .retire_cycles (retire_cycles)
  );

  assign issue_word    = fetch_word;
  assign issue_pc      = slot_pc;
  assign issue_valid   = (slot_kind == SLOT_EXEC);
  assign issue_operand = (slot_kind == SLOT_OPER);

endmodule

// File: tb/tb_fetch_skip_seq.sv
module tb_fetch_skip_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int WW = 16;
  localparam int CW = 2;
  localparam int DEPTH = 1 << AW;
  localparam int M_RUN = 0, M_OPER = 1, M_FSK = 2, M_FTL = 3, M_FPC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] fetch_addr;
  logic [WW-1:0] fetch_word;
  logic          skip_taken = 1'b0, pc_write = 1'b0;
  logic [AW-1:0] pc_target = '0;
  logic [WW-1:0] issue_word;
  logic [AW-1:0] issue_pc, retire_pc;
  logic          issue_valid, issue_operand, retire_valid;
  logic [CW-1:0] retire_cycles;

  logic [WW-1:0] mem [0:DEPTH-1];

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  int            m_state;
  logic [AW-1:0] m_pc, m_start, m_tgt;
  bit            m_both, e_rv, ign_prev, first_slot, after_flush_rst;
  logic [AW-1:0] e_rpc;
  int            e_rcyc;
  string         e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) fetch_word <= mem[fetch_addr];

  fetch_skip_seq dut (
    .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .fetch_word(fetch_word),
    .skip_taken(skip_taken), .pc_write(pc_write), .pc_target(pc_target),
    .issue_word(issue_word), .issue_pc(issue_pc), .issue_valid(issue_valid),
    .issue_operand(issue_operand), .retire_valid(retire_valid),
    .retire_pc(retire_pc), .retire_cycles(retire_cycles)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic bit dir_skip(input logic [AW-1:0] pc);
    return pc == 0 || pc == 2 || pc == 5 || pc == 6 || pc == 20 || pc == 41;
  endfunction

  function automatic bit dir_jump(input logic [AW-1:0] pc);
    return pc == 5 || pc == 7 || pc == 8 || pc == 20;
  endfunction

  function automatic logic [AW-1:0] dir_target(input logic [AW-1:0] pc);
    if (pc == 8)  return AW'(20);
    if (pc == 20) return AW'(40);
    return AW'(100);
  endfunction

  function automatic logic [WW-1:0] rand_word();
    int r;
    logic [3:0] nib;
    r = $urandom % 8;
    if (r == 0)      nib = 4'hC;
    else if (r == 1) nib = 4'hF;
    else             nib = 4'($urandom % 12);
    return {nib, 12'($urandom)};
  endfunction

  task automatic fill_directed();
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'h1000 | WW'(i & 12'hfff);
    mem[3] = 16'hC0AB; mem[4] = 16'hF0CD;
    mem[5] = 16'hC123; mem[6] = 16'hF456;
    mem[7] = 16'hF789;
    mem[21] = 16'hC111; mem[22] = 16'hF222;
    mem[42] = 16'hF333;
  endtask

  task automatic fill_random();
    for (int i = 0; i < DEPTH; i++) mem[i] = rand_word();
    mem[0] = 16'h2345;
  endtask

  task automatic reset_check();
    check(fetch_addr, 0, "R1 fetch_addr in reset");
    check(issue_valid, 0, "R1 issue_valid in reset");
    check(issue_operand, 0, "R1 issue_operand in reset");
    check(retire_valid, 0, "R1 retire_valid in reset");
  endtask

  // Called at a negedge; leaves reset released with ignored stimulus for the boot slot.
  task automatic do_reset(input bit refill, input bit mid_flush);
    rst = 1'b1; skip_taken = 1'b0; pc_write = 1'b0;
    if (refill) fill_random();
    repeat (2) @(negedge clk);
    reset_check();
    rst = 1'b0;
    skip_taken = 1'b1; pc_write = 1'b1; pc_target = AW'($urandom);  // R9: boot slot
    m_state = M_RUN; m_pc = '0; e_rv = 1'b0; ign_prev = 1'b0;
    first_slot = 1'b1; after_flush_rst = mid_flush;
  endtask

  task automatic step(input bit directed);
    logic [WW-1:0] w;
    bit hd, tl, d_skip, d_jump, is_exec;
    logic [AW-1:0] d_tgt;
    int exp_v, exp_o;
    string tag;
    w  = mem[m_pc];
    hd = (w[15:12] == 4'hC);
    tl = (w[15:12] == 4'hF);

    check(retire_valid, e_rv, "R10 retire strobe");
    if (e_rv) begin
      check(retire_pc, e_rpc, {e_tag, " retire pc"});
      check(retire_cycles, e_rcyc, {e_tag, " retire cycles"});
    end
    check(issue_pc, m_pc, first_slot ? "R1 first issue address" : "R2 issue address");
    check(issue_word, w, "R2 issue word");

    case (m_state)
      M_RUN:   begin exp_v = tl ? 0 : 1; exp_o = 0; tag = tl ? "R8" : (hd ? "R7" : "R2"); end
      M_OPER:  begin exp_v = 0; exp_o = 1; tag = "R7"; end
      M_FSK:   begin exp_v = 0; exp_o = 0; tag = "R3"; end
      M_FTL:   begin exp_v = 0; exp_o = 0; tag = "R4"; end
      default: begin exp_v = 0; exp_o = 0; tag = "R5"; end
    endcase
    if (ign_prev) tag = "R9";
    check(issue_valid, exp_v, {tag, " issue_valid"});
    check(issue_operand, exp_o, {tag, " issue_operand"});
    if (m_state == M_FPC) check(fetch_addr, m_tgt, "R5 fetch address after jump");
    if (after_flush_rst) check(issue_valid, 1, "R11 address 0 valid after reset in flush");
    first_slot = 1'b0; after_flush_rst = 1'b0;

    if (directed) begin
      d_skip = dir_skip(m_pc); d_jump = dir_jump(m_pc); d_tgt = dir_target(m_pc);
    end else begin
      d_skip = ($urandom % 4) == 0; d_jump = ($urandom % 6) == 0; d_tgt = AW'($urandom);
    end
    skip_taken = d_skip; pc_write = d_jump; pc_target = d_tgt;
    is_exec = (m_state == M_RUN) && !hd && !tl;
    ign_prev = (d_skip || d_jump) && !is_exec;

    e_rv = 1'b0;
    case (m_state)
      M_RUN: begin
        if (tl) begin
          e_rv = 1'b1; e_rpc = m_pc; e_rcyc = 1; e_tag = "R8";
        end else if (hd) begin
          m_start = m_pc; m_state = M_OPER;
        end else begin
          m_start = m_pc;
          if (d_jump) begin
            m_tgt = d_tgt; m_both = d_skip; m_state = M_FPC;
          end else if (d_skip) begin
            m_state = M_FSK;
          end else begin
            e_rv = 1'b1; e_rpc = m_pc; e_rcyc = 1; e_tag = "R2";
          end
        end
        m_pc = m_pc + 1'b1;
      end
      M_OPER: begin
        e_rv = 1'b1; e_rpc = m_start; e_rcyc = 2; e_tag = "R7";
        m_state = M_RUN; m_pc = m_pc + 1'b1;
      end
      M_FSK: begin
        if (hd) m_state = M_FTL;
        else begin
          e_rv = 1'b1; e_rpc = m_start; e_rcyc = 2; e_tag = "R3"; m_state = M_RUN;
        end
        m_pc = m_pc + 1'b1;
      end
      M_FTL: begin
        e_rv = 1'b1; e_rpc = m_start; e_rcyc = 3; e_tag = "R4";
        m_state = M_RUN; m_pc = m_pc + 1'b1;
      end
      default: begin
        e_rv = 1'b1; e_rpc = m_start; e_rcyc = 2; e_tag = m_both ? "R6" : "R5";
        m_state = M_RUN; m_pc = m_tgt;
      end
    endcase
  endtask

  initial begin
    void'($urandom(32'h5EED));
    fill_directed();
    @(negedge clk);
    do_reset(1'b0, 1'b0);
    fill_directed();
    repeat (40) begin
      @(negedge clk);
      step(1'b1);
    end
    @(negedge clk);
    do_reset(1'b1, 1'b0);
    repeat (4000) begin
      @(negedge clk);
      if ((m_state == M_FSK || m_state == M_FTL || m_state == M_FPC) && ($urandom % 40) == 0)
        do_reset(1'b0, 1'b1);  // R11
      else
        step(1'b0);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule